// File: doc/BRIEF.md
# State Equivalence Reducer

This block finds which states of a finite state machine can be merged. The machine has one input bit, a completely specified transition table and at most `NS` states. Software or a loader writes one row per state: the successor under input 0, the successor under input 1, and the output bit for each input value. After a start pulse, the block keeps a triangular bit matrix with one bit for every unordered pair of distinct states, where a set bit means "distinguishable".

In its first step the block marks every pair whose outputs differ. It then runs passes over all pairs in parallel. In each pass, a pair becomes marked if a pair formed by its two successors under the same input value is already marked. Passes stop after the first one that changes nothing.

A final step maps every state to the lowest-indexed state of its equivalence class and raises `done`. The caller reads the merged machine from `rep_flat` and rebuilds the reduced table from the representatives.

Top module: `eqv_reducer`

## Requirements
- R1: After reset, `busy` and `done` are low and every representative field holds its own state index.
- R2: A row is stored at `wr_idx` when `wr_en` is high while `busy` is low. The row holds the successor for input 0 (`wr_nx0`), the successor for input 1 (`wr_nx1`) and the two output bits. Writes while `busy` is high are dropped.
- R3: Two states whose outputs differ for input 0 or for input 1 never end in the same class.
- R4: The classes produced are exactly the classes of state equivalence of the loaded table. Two states are equivalent when, for every input sequence, they produce the same output sequence. Pairs that imply each other are therefore merged.
- R5: Field j of `rep_flat` (bits j*SW upward) holds the lowest index in the class of state j. It is never above j, and a state that is equivalent to no other state keeps its own index.
- R6: A state with an index at or above the `num_states` value sampled at start is treated as a class of its own, so its field holds its own index.
- R7: `start` and `num_states` are ignored while `busy` is high.
- R8: `done` rises when a run completes and stays high, with `rep_flat` unchanged, until the next accepted start. An accepted start clears `done`.
- R9: `done` is high no later than `num_states`+2 rising edges after the edge that accepts `start` (2 ≤ `num_states` ≤ `NS`).
- R10: `busy` is high from the edge that accepts `start` until `done` rises, and `busy` and `done` are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; sampled only while idle |
| num_states | input | SW+1 | Number of valid states, sampled with start |
| wr_en | input | 1 | Row write strobe |
| wr_idx | input | SW | Row being written |
| wr_nx0 | input | SW | Successor state for input 0 |
| wr_nx1 | input | SW | Successor state for input 1 |
| wr_o0 | input | 1 | Output bit for input 0 |
| wr_o1 | input | 1 | Output bit for input 1 |
| busy | output | 1 | Run in progress |
| done | output | 1 | Results valid |
| rep_flat | output | NS*SW | Per-state class representative, state j in bits j*SW +: SW |

## Verification
The hardest case to reach from the ports is a long chain of passes. In such a chain, a pair is separated only because a pair it implies was separated in an earlier pass, several steps removed from any output difference. Uniform random tables seldom give this, because most pairs split in the first step.

The stimulus therefore builds many random tables by cloning earlier rows, so that many pairs start out equivalent and only later mismatches split them. These tables are mixed with directed tables: one with a three-state class and mutually implying pairs, and one with identical outputs everywhere.

// File: rtl/eqv_reducer.sv
module eqv_reducer #(
  parameter int NS = 8,
  parameter int SW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SW:0]      num_states,
  input  logic             wr_en,
  input  logic [SW-1:0]    wr_idx,
  input  logic [SW-1:0]    wr_nx0,
  input  logic [SW-1:0]    wr_nx1,
  input  logic             wr_o0,
  input  logic             wr_o1,
  output logic             busy,
  output logic             done,
  output logic [NS*SW-1:0] rep_flat
);
  localparam int NP = NS * NS;
  localparam int RW = 2 * SW + 2;

  typedef enum logic [1:0] {S_IDLE, S_INIT, S_PASS, S_GROUP} st_t;

  st_t                   st;
  logic                  done_q;
  logic [NS-1:0][RW-1:0] row;
  logic [NP-1:0]         mk, init_mk, nmk;
  logic [NS-1:0][SW-1:0] rep, rep_n;
  logic [SW:0]           num_r, pcnt;
  logic                  changed;

  function automatic logic pm(input logic [NP-1:0] m, input logic [SW-1:0] a, input logic [SW-1:0] b);
    if (a == b) return 1'b0;
    if (a < b) return m[int'(a) * NS + int'(b)];
    return m[int'(b) * NS + int'(a)];
  endfunction

  function automatic logic [SW-1:0] nx(input logic [RW-1:0] r, input logic x);
    return x ? r[2*SW-1:SW] : r[SW-1:0];
  endfunction

  assign busy     = (st != S_IDLE);
  assign done     = done_q;
  assign rep_flat = rep;
  assign changed  = (nmk != mk);

  always_comb begin
    init_mk = '0;
    nmk     = '0;
    for (int i = 0; i < NS; i++)
      for (int j = 0; j < NS; j++)
        if (i < j) begin
          init_mk[i*NS+j] = (row[i][RW-1] ^ row[j][RW-1]) | (row[i][RW-2] ^ row[j][RW-2])
                            | (j >= int'(num_r));
          nmk[i*NS+j] = mk[i*NS+j]
                        | pm(mk, nx(row[i], 1'b0), nx(row[j], 1'b0))
                        | pm(mk, nx(row[i], 1'b1), nx(row[j], 1'b1));
        end
  end

  always_comb begin
    for (int j = 0; j < NS; j++) begin
      rep_n[j] = '0;
      for (int i = NS - 1; i >= 0; i--)
        if (i <= j && (i == j || !mk[i*NS+j])) rep_n[j] = i[SW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      done_q <= 1'b0;
      mk     <= '0;
      pcnt   <= '0;
      num_r  <= '0;
      row    <= '0;
      for (int k = 0; k < NS; k++) rep[k] <= k[SW-1:0];
    end else begin
      if (wr_en && st == S_IDLE) row[wr_idx] <= {wr_o1, wr_o0, wr_nx1, wr_nx0};
      case (st)
        S_IDLE: if (start) begin
          st     <= S_INIT;
          done_q <= 1'b0;
          num_r  <= num_states;
        end
        S_INIT: begin
          mk   <= init_mk;
          pcnt <= '0;
          st   <= S_PASS;
        end
        S_PASS: begin
          mk   <= nmk;
          pcnt <= pcnt + 1'b1;
          if (!changed) st <= S_GROUP;
        end
        default: begin
          rep    <= rep_n;
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
      endcase
    end
  end

  logic rep_ok, bad_out;
  always_comb begin
    rep_ok  = 1'b1;
    bad_out = 1'b0;
    for (int j = 0; j < NS; j++) begin
      if (int'(rep[j]) > j) rep_ok = 1'b0;
      if (rep[rep[j]] != rep[j]) rep_ok = 1'b0;
      if (row[rep[j]][RW-1:RW-2] != row[j][RW-1:RW-2]) bad_out = 1'b1;
    end
  end

  p_table_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(row));
  p_out_split_r3:    assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> !bad_out);
  p_rep_lowest_r5:   assert property (@(posedge clk) disable iff (!rst_n) done |-> rep_ok);
  p_start_ign_r7:    assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(num_r));
  p_done_hold_r8:    assert property (@(posedge clk) disable iff (!rst_n) (done && !start) |=> done);
  p_rep_hold_r8:     assert property (@(posedge clk) disable iff (!rst_n) (done && !start) |=> $stable(rep_flat));
  p_pass_bound_r9:   assert property (@(posedge clk) disable iff (!rst_n)
                       (st == S_PASS && num_r > 1) |-> (pcnt < num_r - 1'b1));
  p_busy_done_r10:   assert property (@(posedge clk) disable iff (!rst_n) !(busy && done));
endmodule

// File: tb/eqv_reducer_tb.sv
`timescale 1ns/1ps
module eqv_reducer_tb;
  localparam int NS = 8;
  localparam int SW = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, wr_en = 1'b0, wr_o0 = 1'b0, wr_o1 = 1'b0;
  logic [SW:0] num_states = '0;
  logic [SW-1:0] wr_idx = '0, wr_nx0 = '0, wr_nx1 = '0;
  logic busy, done;
  logic [NS*SW-1:0] rep_flat;

  eqv_reducer #(.NS(NS), .SW(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .num_states(num_states),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_nx0(wr_nx0), .wr_nx1(wr_nx1),
    .wr_o0(wr_o0), .wr_o1(wr_o1), .busy(busy), .done(done), .rep_flat(rep_flat));

  int checks = 0, fails = 0;
  int tn0[NS], tn1[NS], to0[NS], to1[NS], exp_rep[NS];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int rep_of(input int j);
    return int'(rep_flat[j*SW +: SW]);
  endfunction

  task automatic model(input int n);
    int cls[NS], nc[NS];
    for (int i = 0; i < n; i++) cls[i] = to0[i] * 2 + to1[i];
    for (int it = 0; it <= NS; it++) begin
      for (int i = 0; i < n; i++) begin
        nc[i] = i;
        for (int k = n - 1; k >= 0; k--)
          if (cls[k] == cls[i] && cls[tn0[k]] == cls[tn0[i]] && cls[tn1[k]] == cls[tn1[i]]) nc[i] = k;
      end
      for (int i = 0; i < n; i++) cls[i] = nc[i];
    end
    for (int i = 0; i < NS; i++) exp_rep[i] = (i < n) ? cls[i] : i;
  endtask

  task automatic load(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_idx = i[SW-1:0]; wr_nx0 = tn0[i][SW-1:0]; wr_nx1 = tn1[i][SW-1:0];
      wr_o0 = to0[i][0]; wr_o1 = to1[i][0];
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n, input bit poke_start, input bit poke_wr);
    int lat;
    @(negedge clk);
    num_states = n[SW:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10 busy after start", int'(busy), 1);
    chk(done == 1'b0, "R8 done cleared by start", int'(done), 0);
    lat = 0;
    while (!done && lat < 40) begin
      if (lat == 0 && poke_start) begin start = 1'b1; num_states = 4'd1; end
      if (lat == 0 && poke_wr) begin
        wr_en = 1'b1; wr_idx = '0; wr_nx0 = 3'd7; wr_nx1 = 3'd6; wr_o0 = ~to0[0][0]; wr_o1 = 1'b1;
      end
      @(negedge clk);
      start = 1'b0; wr_en = 1'b0; num_states = n[SW:0];
      lat++;
      if (!done) chk(busy == 1'b1, "R10 busy until done", int'(busy), 1);
    end
    chk(done == 1'b1 && lat <= n + 2, "R9 completion latency", lat, n + 2);
    chk(!busy, "R10 busy low with done", int'(busy), 0);
    model(n);
    for (int j = 0; j < NS; j++)
      if (j < n) chk(rep_of(j) == exp_rep[j], "R4 R5 representative", rep_of(j), exp_rep[j]);
      else chk(rep_of(j) == j, "R6 unused state", rep_of(j), j);
  endtask

  task automatic hold_check();
    logic [NS*SW-1:0] snap;
    snap = rep_flat;
    repeat (5) @(negedge clk);
    chk(done == 1'b1, "R8 done holds", int'(done), 1);
    chk(rep_flat == snap, "R8 reps hold", int'(rep_flat), int'(snap));
  endtask

  task automatic set_row(input int i, input int a, input int b, input int p, input int q);
    tn0[i] = a; tn1[i] = b; to0[i] = p; to1[i] = q;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R1 reset flags", int'({busy, done}), 0);
    for (int j = 0; j < NS; j++) chk(rep_of(j) == j, "R1 reset reps", rep_of(j), j);

    // seven-state table with a three-member class
    set_row(0,3,0,0,0); set_row(1,4,0,0,0); set_row(2,6,5,0,1); set_row(3,0,3,1,0);
    set_row(4,0,3,1,0); set_row(5,2,1,0,0); set_row(6,0,4,1,0);
    load(7);
    run(7, 1'b0, 1'b0);
    chk(rep_of(1) == 0 && rep_of(4) == 3 && rep_of(6) == 3, "R4 directed seven", rep_of(6), 3);
    chk(rep_of(2) == 2 && rep_of(5) == 5, "R3 singletons", rep_of(5), 5);
    hold_check();

    // mutually implying pairs
    set_row(0,2,1,0,1); set_row(1,3,0,0,1); set_row(2,0,3,1,0); set_row(3,1,3,1,0);
    load(4);
    run(4, 1'b1, 1'b0);
    chk(rep_of(1) == 0 && rep_of(3) == 2, "R7 R4 mutual pairs", rep_of(3), 2);
    run(4, 1'b0, 1'b1);
    run(4, 1'b0, 1'b0);
    chk(rep_of(0) == 0 && rep_of(2) == 2, "R2 write during busy dropped", rep_of(2), 2);

    // identical outputs everywhere
    for (int i = 0; i < NS; i++) set_row(i, int'($urandom % NS), int'($urandom % NS), 0, 0);
    load(NS);
    run(NS, 1'b0, 1'b0);
    for (int j = 0; j < NS; j++) chk(rep_of(j) == 0, "R4 all equivalent", rep_of(j), 0);

    for (int t = 0; t < 40; t++) begin
      int n;
      n = 2 + int'($urandom % (NS - 1));
      for (int i = 0; i < n; i++) begin
        if (i > 0 && ($urandom % 3) != 0) begin
          int k;
          k = int'($urandom % i);
          set_row(i, tn0[k], tn1[k], to0[k], to1[k]);
          if ($urandom % 4 == 0) tn1[i] = int'($urandom % n);
        end else set_row(i, int'($urandom % n), int'($urandom % n), int'($urandom % 2), int'($urandom % 2));
        if (tn0[i] >= n) tn0[i] = int'($urandom % n);
        if (tn1[i] >= n) tn1[i] = int'($urandom % n);
      end
      load(n);
      run(n, t % 5 == 0, t % 7 == 0);
    end
    hold_check();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule